// File: doc/BRIEF.md
# Prescaled Dual-Compare Interval Timer

This block is a single 16-bit interval timer channel that runs from the system clock. Software sets it up through a small write-only register port. There is one control word and two limit registers. A field in the control word picks which limit sets the period. The period is the chosen limit multiplied by a power-of-two prescale factor.

When a period ends, the channel raises a one-cycle expiry pulse. If interrupts are enabled, it raises an interrupt request in the same cycle. After that the channel either reloads and runs again, or it stops. The control word picks which.

Any write to the control word restarts the channel from zero with the new settings. A channel that is set to count but has no usable period does not run, and it raises a configuration error flag.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `expire_o`, `irq_o`, `cfg_err_o` and `running_o` are low, and no expiry occurs until the control word is written.
- R2: The control word is at `wr_addr` 0, limit A at 1 and limit B at 2. Control bits [5:4] select the limit: 1 selects limit A and 2 selects limit B. One period is 2^n × limit system clock cycles, where n is control bits [13:10]. The first expiry pulse appears 1 + period cycles after the clock edge that accepts the control write.
- R3: A prescale exponent in bits [13:10] above 8 behaves exactly as 8.
- R4: A compare select of 0 or 3 gives no valid period. If the channel is otherwise enabled, it stays idle and `cfg_err_o` is high from the cycle after the restart.
- R5: A selected limit of zero, either at a restart or at a repeat reload, stops the channel and sets `cfg_err_o`.
- R6: A clock source field (bits [15:14]) other than 0 keeps the channel idle without flagging an error.
- R7: With the halt bit (bit 1) set, the channel stays idle and no expiry occurs.
- R8: With the repeat bit (bit 7) set, expiries recur every period without a further write.
- R9: With bit 7 clear, the channel expires once and then `running_o` goes low and no further expiry occurs.
- R10: `irq_o` pulses together with `expire_o` exactly when interrupt enable (bit 2) is set.
- R11: `expire_o` is high for a single cycle per expiry when the period is longer than one cycle.
- R12: A control write while the channel is running restarts counting from zero with the new settings.
- R13: A limit register write while the channel runs takes effect only at the next reload or restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 limit A, 2 limit B, 3 unused |
| wr_data | input | 16 | Write data |
| expire_o | output | 1 | One-cycle pulse at the end of each period |
| irq_o | output | 1 | Interrupt request pulse, qualified by the enable bit |
| cfg_err_o | output | 1 | Enabled channel has no usable period |
| running_o | output | 1 | Channel is counting |

## Verification
The bench builds the channel with a 16-bit counter and a maximum prescale exponent of 8. These are the defaults, so the exponent clamp can be reached directly with exponents 9 through 15 and compared against an exponent of 8. Limits are kept small so that periods stay within a few thousand cycles. This lets randomly chosen exponents from 0 to 10 run against both limit registers inside the cycle budget. Single-cycle periods, zero limits, and reloads that pick up a changed limit are driven as directed cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LIM_A = 2'd1,
    REG_LIM_B = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam logic [1:0] CMP_LIM_A = 2'd1;
  localparam logic [1:0] CMP_LIM_B = 2'd2;
  localparam logic [1:0] SRC_SYSCLK = 2'd0;

  typedef struct packed {
    logic [1:0] clk_src;    // 15:14
    logic [3:0] pre_exp;    // 13:10
    logic [1:0] rsv_a;      // 9:8
    logic       rpt;        // 7
    logic       rsv_b;      // 6
    logic [1:0] cmp_sel;    // 5:4
    logic       rsv_c;      // 3
    logic       irq_en;     // 2
    logic       halt;       // 1
    logic       rsv_d;      // 0
  } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [15:0]           wr_data,
  output tmr_pkg::ctrl_t        ctrl_q,
  output logic [CNT_W-1:0]      lim_a_q,
  output logic [CNT_W-1:0]      lim_b_q,
  output logic                  restart_q
);
  import tmr_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      lim_a_q   <= '0;
      lim_b_q   <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          REG_CTRL: begin
            ctrl_q    <= ctrl_t'(wr_data);
            restart_q <= 1'b1;
          end
          REG_LIM_A: lim_a_q <= wr_data[CNT_W-1:0];
          REG_LIM_B: lim_b_q <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // restart follows only a control write
  p_restart_src_r12: assert property (@(posedge clk) disable iff (rst)
    restart_q |-> $past(wr_en && wr_addr == REG_CTRL));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MAX_EXP = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [3:0] exp_raw,
  output logic       tick
);
  localparam int PRE_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [3:0]       exp_c;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] mask;
  logic [PRE_W-1:0] pre_q;

  assign exp_c   = (exp_raw > 4'(MAX_EXP)) ? 4'(MAX_EXP) : exp_raw;
  assign one_hot = {{PRE_W{1'b0}}, 1'b1} << exp_c;
  assign mask    = PRE_W'(one_hot - 1'b1);
  assign tick    = run && (pre_q == mask);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) pre_q <= '0;
    else if (tick)            pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end

  // prescaler never passes the clamped terminal value
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
    !clear |-> pre_q <= mask);

  p_pre_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> pre_q == '0);

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [1:0]       clk_src,
  input  logic             halt,
  input  logic             rpt,
  input  logic             irq_en,
  input  logic [1:0]       cmp_sel,
  input  logic [CNT_W-1:0] lim_a,
  input  logic [CNT_W-1:0] lim_b,
  output logic             run_q,
  output logic             expire_q,
  output logic             irq_q,
  output logic             err_q
);
  import tmr_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] sel_lim;
  logic             sel_ok;
  logic             enabled;
  logic             period_ok;

  always_comb begin
    sel_ok  = 1'b1;
    sel_lim = '0;
    case (cmp_sel)
      CMP_LIM_A: sel_lim = lim_a;
      CMP_LIM_B: sel_lim = lim_b;
      default:   sel_ok  = 1'b0;
    endcase
  end

  assign enabled   = (clk_src == SRC_SYSCLK) && !halt;
  assign period_ok = sel_ok && (sel_lim != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      lim_q    <= '0;
      run_q    <= 1'b0;
      expire_q <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      irq_q    <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
        lim_q <= sel_lim;
        run_q <= enabled && period_ok;
        err_q <= enabled && !period_ok;
      end else if (run_q && tick) begin
        if (cnt_q == lim_q - 1'b1) begin
          expire_q <= 1'b1;
          irq_q    <= irq_en;
          cnt_q    <= '0;
          if (rpt) begin
            lim_q <= sel_lim;
            run_q <= period_ok;
            err_q <= !period_ok;
          end else begin
            run_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_cnt_below_lim_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q < lim_q);

  p_restart_zero_r12: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);

  p_idle_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    (restart && (halt || clk_src != SRC_SYSCLK)) |=> (!run_q && !err_q));

  p_zero_lim_r5: assert property (@(posedge clk) disable iff (rst)
    (restart && clk_src == SRC_SYSCLK && !halt && sel_lim == '0) |=> (!run_q && err_q));

  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (expire_q && !rpt && !restart) |-> !run_q);

  p_irq_with_exp_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> expire_q);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W   = 16,
  parameter int MAX_EXP = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        expire_o,
  output logic        irq_o,
  output logic        cfg_err_o,
  output logic        running_o
);
  import tmr_pkg::*;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] lim_a;
  logic [CNT_W-1:0] lim_b;
  logic             restart;
  logic             tick;
  logic             run;
  logic             unused_rsv;

  assign unused_rsv = ^{ctrl.rsv_a, ctrl.rsv_b, ctrl.rsv_c, ctrl.rsv_d};

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl), .lim_a_q(lim_a), .lim_b_q(lim_b), .restart_q(restart)
  );

  tmr_prescale #(.MAX_EXP(MAX_EXP)) u_pre (
    .clk(clk), .rst(rst), .clear(restart), .run(run),
    .exp_raw(ctrl.pre_exp), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick),
    .clk_src(ctrl.clk_src), .halt(ctrl.halt), .rpt(ctrl.rpt),
    .irq_en(ctrl.irq_en), .cmp_sel(ctrl.cmp_sel),
    .lim_a(lim_a), .lim_b(lim_b),
    .run_q(run), .expire_q(expire_o), .irq_q(irq_o), .err_q(cfg_err_o)
  );

  assign running_o = run;

  p_err_not_running_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |-> !running_o);

endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        expire_o, irq_o, cfg_err_o, running_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan #(.CNT_W(16), .MAX_EXP(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire_o(expire_o), .irq_o(irq_o), .cfg_err_o(cfg_err_o), .running_o(running_o)
  );

  function automatic int eff_exp(int n);
    return (n > 8) ? 8 : n;
  endfunction

  function automatic int period(int n, int lim);
    return (1 << eff_exp(n)) * lim;
  endfunction

  function automatic logic [15:0] mk_ctrl(int src, int n, bit rpt, int sel, bit irq, bit halt);
    return {2'(src), 4'(n), 2'b00, rpt, 1'b0, 2'(sel), 1'b0, irq, halt, 1'b0};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(int a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic find_exp(int limit, output int j, output int irqv);
    j = -1; irqv = -1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if (expire_o) begin
        j = i; irqv = int'(irq_o);
        return;
      end
    end
  endtask

  task automatic quiet(string req, int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (expire_o) seen++;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    int j, iv;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 expire", int'(expire_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 err", int'(cfg_err_o), 0);
    chk("R1 running", int'(running_o), 0);
    quiet("R1 no expiry", 40);

    // R2/R10/R11/R9 one-shot on limit A
    wr(1, 16'd5); wr(2, 16'd9);
    wr(0, mk_ctrl(0, 0, 0, 1, 1, 0));
    find_exp(100, j, iv);
    chk("R2 first expiry", j, period(0, 5) + 1);
    chk("R10 irq enabled", iv, 1);
    step();
    chk("R11 pulse width", int'(expire_o), 0);
    chk("R9 stopped", int'(running_o), 0);
    quiet("R9 no repeat", 30);

    // R8/R10 repeat on limit B, irq off
    wr(0, mk_ctrl(0, 2, 1, 2, 0, 0));
    find_exp(200, j, iv);
    chk("R2 limit B period", j, period(2, 9) + 1);
    chk("R10 irq disabled", iv, 0);
    find_exp(200, j, iv);
    chk("R8 repeat period", j, period(2, 9));
    chk("R8 still running", int'(running_o), 1);

    // R13 limit change while running
    wr(2, 16'd3);
    find_exp(200, j, iv);
    chk("R13 old limit kept", j, period(2, 9) - 1);
    find_exp(200, j, iv);
    chk("R13 new limit at reload", j, period(2, 3));

    // R12 restart mid-period
    wr(1, 16'd5);
    wr(0, mk_ctrl(0, 3, 1, 1, 0, 0));
    repeat (10) step();
    chk("R12 no early expiry", int'(expire_o), 0);
    wr(0, mk_ctrl(0, 3, 1, 1, 0, 0));
    find_exp(200, j, iv);
    chk("R12 restart from zero", j, period(3, 5) + 1);

    // R3 clamp
    wr(1, 16'd2);
    wr(0, mk_ctrl(0, 12, 0, 1, 0, 0));
    find_exp(2000, j, iv);
    chk("R3 exp 12 clamped", j, 513);
    wr(0, mk_ctrl(0, 15, 0, 1, 0, 0));
    find_exp(2000, j, iv);
    chk("R3 exp 15 clamped", j, period(8, 2) + 1);

    // R4 invalid select
    wr(0, mk_ctrl(0, 0, 1, 0, 1, 0));
    step();
    chk("R4 sel0 err", int'(cfg_err_o), 1);
    chk("R4 sel0 idle", int'(running_o), 0);
    quiet("R4 sel0 no expiry", 50);
    wr(0, mk_ctrl(0, 0, 1, 3, 1, 0));
    step();
    chk("R4 sel3 err", int'(cfg_err_o), 1);
    quiet("R4 sel3 no expiry", 50);

    // R5 zero limit at restart
    wr(1, 16'd0);
    wr(0, mk_ctrl(0, 0, 1, 1, 0, 0));
    step();
    chk("R5 zero limit err", int'(cfg_err_o), 1);
    chk("R5 zero limit idle", int'(running_o), 0);
    quiet("R5 no expiry", 40);

    // R5 zero limit at reload
    wr(2, 16'd4);
    wr(0, mk_ctrl(0, 0, 1, 2, 0, 0));
    find_exp(50, j, iv);
    chk("R5 run before zero", j, 5);
    chk("R5 err cleared", int'(cfg_err_o), 0);
    wr(2, 16'd0);
    find_exp(50, j, iv);
    chk("R5 last expiry", j, 3);
    chk("R5 reload stops", int'(running_o), 0);
    chk("R5 reload err", int'(cfg_err_o), 1);

    // R6 other clock source
    wr(1, 16'd3);
    wr(0, mk_ctrl(1, 0, 1, 1, 1, 0));
    step();
    chk("R6 idle", int'(running_o), 0);
    chk("R6 no err", int'(cfg_err_o), 0);
    quiet("R6 no expiry", 40);

    // R7 halt
    wr(0, mk_ctrl(0, 0, 1, 1, 1, 1));
    step();
    chk("R7 idle", int'(running_o), 0);
    quiet("R7 no expiry", 40);

    // R2/R10 random one-shot runs
    for (int k = 0; k < 20; k++) begin
      int n = $urandom_range(0, 10);
      int la = $urandom_range(1, 6);
      int lb = $urandom_range(1, 6);
      int sel = $urandom_range(1, 2);
      bit irq = 1'($urandom_range(0, 1));
      int p = period(n, (sel == 1) ? la : lb);
      wr(1, 16'(la)); wr(2, 16'(lb));
      wr(0, mk_ctrl(0, n, 0, sel, irq, 0));
      find_exp(p + 10, j, iv);
      chk("R2 random period", j, p + 1);
      chk("R10 random irq", iv, int'(irq));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule